// File: doc/BRIEF.md
# Phase-Interleaved Shared Memory Switch

This block gives one host processor write and read reach into the private RAM of several satellite boards without ever stalling them. A shared memory cycle is four input clocks long. The first two clocks form the host half and the last two form the local half. During the host half, each board's RAM is connected to the host bus, but only if the host has picked that board. During the local half, the RAM is connected to the board's own local port. Every board uses the same phase, so one host write can update any single board, a chosen group of boards, or all of them at once (for example, to load a shared parameter set).

There is no arbitration, no stall and no back-pressure. Each port has two outputs, `host_phase` and `phase_last`, which show which half is running and whether the current clock is its last one. A transfer is taken exactly on the last clock of its own half, and it is always accepted. Input values driven on any other clock have no effect. A host read returns its data together with a one-clock `host_rvalid` pulse. A local read updates that board's `loc_rdata` at the end of every local half.

Top module: `phase_mem_switch`

## Requirements
- R1: A free-running divide-by-4 counter sets the phase. After reset it runs: host half, first clock (`host_phase`=1, `phase_last`=0); host half, last clock (1,1); local half, first clock (0,0); local half, last clock (0,1). It then repeats. All boards share this phase.
- R2: On every last clock of the local half, each board's local access is carried out, whatever the host is doing. A board whose `loc_we` is high then stores `loc_wdata` at `loc_addr`.
- R3: A host write (`host_req`=1, `host_we`=1) on the last clock of the host half stores `host_wdata` at `host_addr` in every board whose `host_sel` bit is set. Bit i selects board i, and more than one bit may be set.
- R4: A host write with `host_bcast`=1 stores into every board in the same memory cycle, whatever `host_sel` holds.
- R5: A host read (`host_req`=1, `host_we`=0) with exactly one `host_sel` bit set and `host_bcast`=0 returns that board's word at `host_addr` on `host_rdata`. The result comes with `host_rvalid`=1 during the clock right after the commit clock.
- R6: A host read with `host_bcast`=1, or with zero or several `host_sel` bits set, is rejected. It returns all-ones with `host_rvalid`, and no board's contents change.
- R7: During the host half, a board that is not selected (and not reached by broadcast) gets no write. A host write with no board selected changes nothing.
- R8: A local port reaches only its own board's RAM. `loc_rdata` for board i shows the word at `loc_addr` as it was before any write in that same commit.
- R9: Host or local requests driven only on the first clock of a half are ignored.
- R10: While reset is active, `host_phase`=1, `phase_last`=0, `host_rvalid`=0, `host_rdata`=0 and every `loc_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four per memory cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| host_phase | output | 1 | 1 during the host half |
| phase_last | output | 1 | 1 on the commit clock of the current half |
| host_req | input | 1 | Host transfer request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_sel | input | N_BOARDS | Board select, bit i for board i |
| host_bcast | input | 1 | Write to all boards |
| host_rdata | output | DATA_W | Host read result |
| host_rvalid | output | 1 | Read result valid pulse |
| loc_addr | input | N_BOARDS*ADDR_W | Per-board local address, board i at slice i |
| loc_wdata | input | N_BOARDS*DATA_W | Per-board local write data |
| loc_we | input | N_BOARDS | Per-board local write enable |
| loc_rdata | output | N_BOARDS*DATA_W | Per-board local read data |

## Verification
The assertions check on every cycle:
- the strict four-clock phase sequence;
- that each board's local write reaches its RAM on every local commit, so no satellite is ever stalled;
- that boards not selected see no write during the host half;
- that read pulses line up with a read commit, and that rejected reads return all-ones.

Data integrity can only be shown by the bench's scenarios: host and local writes to different addresses of one board within a single memory cycle, broadcast and multi-select fills, proof that one board's local port leaves another board alone, and requests that are ignored because they fall off the commit clock.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic {
    HALF_HOST  = 1'b0,
    HALF_LOCAL = 1'b1
  } half_e;
endpackage

// File: rtl/pms_phase_gen.sv
module pms_phase_gen
  import pms_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output half_e half,
  output logic  last
);
  logic [1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= 2'd0;
    else        cnt <= cnt + 2'd1;
  end

  assign half = cnt[1] ? HALF_LOCAL : HALF_HOST;
  assign last = cnt[0];
endmodule

// File: rtl/pms_board_ram.sv
module pms_board_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_half,
  input  logic              last,
  input  logic              host_hit,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  input  logic              loc_we,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] loc_rdata,
  output logic              bus_we
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;

  always_comb begin
    if (host_half) begin
      bus_addr  = host_hit ? host_addr  : '0;
      bus_wdata = host_hit ? host_wdata : '0;
      bus_we    = host_hit & host_req & host_we & last;
    end else begin
      bus_addr  = loc_addr;
      bus_wdata = loc_wdata;
      bus_we    = loc_we & last;
    end
  end

  assign q = mem[bus_addr];

  always_ff @(posedge clk) begin
    if (bus_we) mem[bus_addr] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 loc_rdata <= '0;
    else if (!host_half && last) loc_rdata <= mem[bus_addr];
  end
endmodule

// File: rtl/pms_host_read.sv
module pms_host_read #(
  parameter int N_BOARDS = 4,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire,
  input  logic [N_BOARDS-1:0]        sel,
  input  logic                       bcast,
  input  logic [N_BOARDS*DATA_W-1:0] q_flat,
  output logic [DATA_W-1:0]          rdata,
  output logic                       rvalid
);
  logic              single;
  logic [DATA_W-1:0] picked;

  assign single = !bcast && ($countones(sel) == 1);

  always_comb begin
    picked = '0;
    for (int i = 0; i < N_BOARDS; i++)
      if (sel[i]) picked = picked | q_flat[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= fire;
      if (fire) rdata <= single ? picked : '1;
    end
  end
endmodule

// File: rtl/phase_mem_switch.sv
module phase_mem_switch
  import pms_pkg::*;
#(
  parameter int N_BOARDS = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic                       host_phase,
  output logic                       phase_last,
  input  logic                       host_req,
  input  logic                       host_we,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [DATA_W-1:0]          host_wdata,
  input  logic [N_BOARDS-1:0]        host_sel,
  input  logic                       host_bcast,
  output logic [DATA_W-1:0]          host_rdata,
  output logic                       host_rvalid,
  input  logic [N_BOARDS*ADDR_W-1:0] loc_addr,
  input  logic [N_BOARDS*DATA_W-1:0] loc_wdata,
  input  logic [N_BOARDS-1:0]        loc_we,
  output logic [N_BOARDS*DATA_W-1:0] loc_rdata
);
  half_e                      half;
  logic [N_BOARDS-1:0]        brd_we;
  logic [N_BOARDS-1:0]        brd_hit;
  logic [N_BOARDS*DATA_W-1:0] brd_q;
  logic                       rd_fire;

  pms_phase_gen u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .half (half),
    .last (phase_last)
  );

  assign host_phase = (half == HALF_HOST);
  assign brd_hit    = host_sel | {N_BOARDS{host_bcast}};
  assign rd_fire    = host_phase & phase_last & host_req & ~host_we;

  for (genvar g = 0; g < N_BOARDS; g++) begin : g_board
    pms_board_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_half (host_phase),
      .last      (phase_last),
      .host_hit  (brd_hit[g]),
      .host_req  (host_req),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .loc_addr  (loc_addr[g*ADDR_W +: ADDR_W]),
      .loc_wdata (loc_wdata[g*DATA_W +: DATA_W]),
      .loc_we    (loc_we[g]),
      .q         (brd_q[g*DATA_W +: DATA_W]),
      .loc_rdata (loc_rdata[g*DATA_W +: DATA_W]),
      .bus_we    (brd_we[g])
    );
  end

  pms_host_read #(.N_BOARDS(N_BOARDS), .DATA_W(DATA_W)) u_hrd (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (rd_fire),
    .sel   (host_sel),
    .bcast (host_bcast),
    .q_flat(brd_q),
    .rdata (host_rdata),
    .rvalid(host_rvalid)
  );
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int N_BOARDS = 4,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_phase,
  input logic                phase_last,
  input logic                host_req,
  input logic                host_we,
  input logic [N_BOARDS-1:0] host_sel,
  input logic                host_bcast,
  input logic [DATA_W-1:0]   host_rdata,
  input logic                host_rvalid,
  input logic [N_BOARDS-1:0] loc_we,
  input logic [N_BOARDS-1:0] brd_we
);
  AST_HALF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    phase_last |=> (host_phase != $past(host_phase))); // R1
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_last |=> (host_phase == $past(host_phase))); // R1
  AST_LAST_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_last |=> phase_last); // R1
  AST_LOCAL_NEVER_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_phase && phase_last) |-> (brd_we == loc_we)); // R2
  AST_UNSELECTED_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    host_phase |-> ((brd_we & ~(host_sel | {N_BOARDS{host_bcast}})) == '0)); // R7
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_phase && phase_last && host_req && !host_we)); // R5
  AST_REJECT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && $past(host_bcast)) |-> (host_rdata == '1)); // R6
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_phase && host_req && !host_we) |-> (brd_we == '0)); // R6
endmodule

bind phase_mem_switch pms_checker #(.N_BOARDS(N_BOARDS), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_phase (host_phase),
  .phase_last (phase_last),
  .host_req   (host_req),
  .host_we    (host_we),
  .host_sel   (host_sel),
  .host_bcast (host_bcast),
  .host_rdata (host_rdata),
  .host_rvalid(host_rvalid),
  .loc_we     (loc_we),
  .brd_we     (brd_we)
);

// File: tb/sim_phase_mem_switch.sv
module sim_phase_mem_switch;
  localparam int NB = 4;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_phase, phase_last;
  logic host_req = 0, host_we = 0, host_bcast = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [NB-1:0] host_sel = '0;
  logic [DW-1:0] host_rdata;
  logic host_rvalid;
  logic [NB*AW-1:0] loc_addr = '0;
  logic [NB*DW-1:0] loc_wdata = '0;
  logic [NB-1:0] loc_we = '0;
  logic [NB*DW-1:0] loc_rdata;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [NB][1<<AW];
  logic [DW-1:0] exp_q [$];
  string tag_q [$];

  always #2.5ns clk = ~clk;

  phase_mem_switch #(.N_BOARDS(NB), .ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected host read results
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) check("R5 unexpected rvalid", 1, 0);
      else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic wait_slot(input logic want_host);
    @(negedge clk);
    while (!(host_phase == want_host && phase_last)) @(negedge clk);
  endtask

  task automatic host_wr(input logic [NB-1:0] sel, input logic bc,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
    wait_slot(1'b1);
    host_req = 1; host_we = 1; host_sel = sel; host_bcast = bc;
    host_addr = a; host_wdata = d;
    for (int b = 0; b < NB; b++) if (sel[b] || bc) model[b][a] = d;
    @(negedge clk);
    host_req = 0; host_we = 0; host_sel = '0; host_bcast = 0;
  endtask

  task automatic host_rd(input logic [NB-1:0] sel, input logic bc,
                         input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] e;
    e = '1;
    if (!bc && $countones(sel) == 1)
      for (int b = 0; b < NB; b++) if (sel[b]) e = model[b][a];
    wait_slot(1'b1);
    exp_q.push_back(e); tag_q.push_back(tag);
    host_req = 1; host_we = 0; host_sel = sel; host_bcast = bc; host_addr = a;
    @(negedge clk);
    host_req = 0; host_sel = '0; host_bcast = 0;
  endtask

  task automatic loc_op(input int b, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic we, input string tag);
    logic [DW-1:0] e;
    e = model[b][a];
    wait_slot(1'b0);
    loc_addr[b*AW +: AW] = a; loc_wdata[b*DW +: DW] = d; loc_we[b] = we;
    if (we) model[b][a] = d;
    @(negedge clk);
    loc_we = '0;
    check(tag, loc_rdata[b*DW +: DW], e);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 host_phase", host_phase, 1);
    check("R10 phase_last", phase_last, 0);
    check("R10 rvalid/rdata", {host_rvalid, host_rdata}, 0);
    check("R10 loc_rdata", loc_rdata, 0);
    rst_n = 1;

    // R1 phase sequence
    wait_slot(1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 phase sequence", {host_phase, phase_last}, (k == 0) ? 2'b00 :
            (k == 1) ? 2'b01 : (k == 2) ? 2'b10 : 2'b11);
    end

    // R3/R5/R8 single board write, read from both sides
    host_wr(4'b0010, 0, 8'h10, 8'hA5);
    host_rd(4'b0010, 0, 8'h10, "R5 host read board1");
    loc_op(1, 8'h10, 8'h00, 0, "R3 local view board1");

    // R4 broadcast fill, seen by every local port
    host_wr(4'b0000, 1, 8'h20, 8'h3C);
    for (int b = 0; b < NB; b++) loc_op(b, 8'h20, 8'h00, 0, "R4 broadcast reached board");

    // R3 multi-select write
    host_wr(4'b0101, 0, 8'h21, 8'h5A);
    host_wr(4'b1010, 0, 8'h21, 8'hC3);
    host_rd(4'b0001, 0, 8'h21, "R3 multi-select board0");
    host_rd(4'b1000, 0, 8'h21, "R3 multi-select board3");

    // R6 rejected reads
    host_rd(4'b0010, 1, 8'h10, "R6 broadcast read");
    host_rd(4'b0000, 0, 8'h10, "R6 no-select read");
    host_rd(4'b0011, 0, 8'h10, "R6 multi-select read");
    host_rd(4'b0010, 0, 8'h10, "R6 contents kept");

    // R7 write with nothing selected
    host_wr(4'b0000, 0, 8'h20, 8'h00);
    for (int b = 0; b < NB; b++) loc_op(b, 8'h20, 8'h00, 0, "R7 unselected unchanged");

    // R2/R8 host and local writes interleaved in the same memory cycles
    for (int k = 0; k < 4; k++) begin
      host_wr(4'b0100, 0, 8'h30 + 8'(k), 8'h11 + 8'(k));
      loc_op(2, 8'h38 + 8'(k), 8'h80 + 8'(k), 1, "R8 read-before-write");
    end
    for (int k = 0; k < 4; k++) begin
      host_rd(4'b0100, 0, 8'h30 + 8'(k), "R2 host word intact");
      host_rd(4'b0100, 0, 8'h38 + 8'(k), "R2 local word intact");
    end

    // R8 isolation between boards
    host_wr(4'b1000, 0, 8'h40, 8'h55);
    host_wr(4'b0001, 0, 8'h40, 8'h66);
    loc_op(0, 8'h40, 8'h77, 1, "R8 old word returned");
    loc_op(3, 8'h40, 8'h00, 0, "R8 other board untouched");
    loc_op(0, 8'h40, 8'h00, 0, "R8 own board written");

    // R9 requests off the commit clock
    host_wr(4'b0001, 0, 8'h50, 8'h0F);
    @(negedge clk);
    while (!(host_phase && !phase_last)) @(negedge clk);
    host_req = 1; host_we = 1; host_sel = 4'b0001; host_addr = 8'h50; host_wdata = 8'hF0;
    @(negedge clk);
    host_req = 0; host_we = 0; host_sel = '0;
    while (!(!host_phase && !phase_last)) @(negedge clk);
    loc_addr[0 +: AW] = 8'h50; loc_wdata[0 +: DW] = 8'hEE; loc_we[0] = 1;
    @(negedge clk);
    loc_we = '0;
    host_rd(4'b0001, 0, 8'h50, "R9 off-slot writes ignored");

    repeat (8) @(negedge clk);
    check("R5 all reads returned", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule